// File: doc/BRIEF.md
# Sixteen-Word Dual-Read Lookup Memory

This block is a small memory of sixteen words, one bit wide by default, with a single synchronous write port and two combinational read outputs. One read output uses the write address, so it reflects a write in the same cycle it lands. The other read output has its own address and can look at any word at any time, including the word being written.

Two parameters choose the active sense of the write clock and of the write enable. A preload parameter sets the power-up contents, and the default is all zeros. If the enable is held inactive, the block is a fixed lookup table. The write and read interfaces are plain address and data pins with no handshake, because every access completes within one cycle and nothing can stall it.

Top module: `lut_dpram`

## Requirements
- R1: With the default preload, all sixteen words read as zero on both outputs before any write.
- R2: On an active write-clock edge with the enable active, `wr_data` is stored in the word selected by `wr_addr`, and no other word changes.
- R3: `q_wside` always equals the word selected by `wr_addr`. Right after a write edge, it shows the newly stored value without waiting for another edge.
- R4: `q_rside` always equals the word selected by `rd_addr`, whatever the write port is doing. It is combinational, with no output register.
- R5: If the enable is inactive at an active edge, no stored word changes, and both outputs keep their values for unchanged addresses.
- R6: With `CLK_POL` set to inverted, writes occur on the falling edge of `wr_clk` only. A rising edge stores nothing.
- R7: With `EN_POL` set to inverted, a low `wr_enable` allows a write and a high `wr_enable` blocks it.
- R8: Bit i of `INIT_BITS` (word i, for a width of 1) is the power-up content of word i. While the enable is held inactive, the block reads back that pattern unchanged, as a lookup table.
- R9: When `rd_addr` equals `wr_addr` during a write, `q_rside` shows the old word before the edge and the new word right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock. The active edge is set by `CLK_POL`. |
| wr_enable | input | 1 | Write enable. The active level is set by `EN_POL`. |
| wr_addr | input | ADDR_W | Write address, also the address for `q_wside`. |
| wr_data | input | WIDTH | Data to store. |
| rd_addr | input | ADDR_W | Independent read address. |
| q_wside | output | WIDTH | Word at `wr_addr`. |
| q_rside | output | WIDTH | Word at `rd_addr`. |

## Verification
The hardest situation to reach is a write in which the independent read address points at the same word as the write address. The second output then has to change in the same cycle, driven only by the edge, without any change to its own address. The bench sets both addresses equal, stores the inverse of the current word, and samples the second output once just before the edge and once just after it.

A second instance runs with both polarities inverted and an unusual preload pattern. On that instance, a rising edge with an active enable must not write. The bench also holds the enable at its inactive level across a falling edge and checks that nothing is stored.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_INVERTED = 1'b1
  } pol_e;

  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_WIDTH  = 1;
endpackage

// File: rtl/dpram_polarity.sv
module dpram_polarity #(
  parameter dpram_pkg::pol_e CLK_POL = dpram_pkg::POL_NORMAL,
  parameter dpram_pkg::pol_e EN_POL  = dpram_pkg::POL_NORMAL
) (
  input  logic raw_clk,
  input  logic raw_en,
  output logic eff_clk,
  output logic eff_en
);
  generate
    if (CLK_POL == dpram_pkg::POL_INVERTED) begin : g_clk_inv
      assign eff_clk = ~raw_clk;
    end else begin : g_clk_norm
      assign eff_clk = raw_clk;
    end
    if (EN_POL == dpram_pkg::POL_INVERTED) begin : g_en_inv
      assign eff_en = ~raw_en;
    end else begin : g_en_norm
      assign eff_en = raw_en;
    end
  endgenerate
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned ADDR_W = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned WIDTH  = dpram_pkg::DEF_WIDTH,
  localparam int unsigned TOTAL = WIDTH << ADDR_W,
  parameter logic [TOTAL-1:0] INIT_BITS = '0
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  din_i,
  output logic [TOTAL-1:0]  bits_o
);
  logic [TOTAL-1:0] bits_q = INIT_BITS;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      bits_q[addr_i*WIDTH +: WIDTH] <= din_i;
    end
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport #(
  parameter int unsigned ADDR_W = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned WIDTH  = dpram_pkg::DEF_WIDTH,
  localparam int unsigned TOTAL = WIDTH << ADDR_W
) (
  input  logic [TOTAL-1:0]  bits_i,
  input  logic [ADDR_W-1:0] sel_i,
  output logic [WIDTH-1:0]  q_o
);
  always_comb begin
    q_o = bits_i[sel_i*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/lut_dpram.sv
module lut_dpram #(
  parameter int unsigned ADDR_W = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned WIDTH  = dpram_pkg::DEF_WIDTH,
  parameter dpram_pkg::pol_e CLK_POL = dpram_pkg::POL_NORMAL,
  parameter dpram_pkg::pol_e EN_POL  = dpram_pkg::POL_NORMAL,
  localparam int unsigned TOTAL = WIDTH << ADDR_W,
  parameter logic [TOTAL-1:0] INIT_BITS = '0
) (
  input  logic              wr_clk,
  input  logic              wr_enable,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  q_wside,
  output logic [WIDTH-1:0]  q_rside
);
  localparam int unsigned NPORTS = 2;

  logic             clk_act;
  logic             en_act;
  logic [TOTAL-1:0] store_bits;
  logic [NPORTS-1:0][ADDR_W-1:0] port_sel;
  logic [NPORTS-1:0][WIDTH-1:0]  port_q;

  dpram_polarity #(.CLK_POL(CLK_POL), .EN_POL(EN_POL)) u_pol (
    .raw_clk(wr_clk),
    .raw_en (wr_enable),
    .eff_clk(clk_act),
    .eff_en (en_act)
  );

  dpram_store #(.ADDR_W(ADDR_W), .WIDTH(WIDTH), .INIT_BITS(INIT_BITS)) u_store (
    .clk_i (clk_act),
    .en_i  (en_act),
    .addr_i(wr_addr),
    .din_i (wr_data),
    .bits_o(store_bits)
  );

  // Port 0 follows the write address; port 1 has its own address.
  assign port_sel[0] = wr_addr;
  assign port_sel[1] = rd_addr;

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
      dpram_rdport #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_rd (
        .bits_i(store_bits),
        .sel_i (port_sel[p]),
        .q_o   (port_q[p])
      );
    end
  endgenerate

  assign q_wside = port_q[0];
  assign q_rside = port_q[1];
endmodule

// File: rtl/lut_dpram_chk.sv
module lut_dpram_chk #(
  parameter int unsigned ADDR_W = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned WIDTH  = dpram_pkg::DEF_WIDTH,
  parameter dpram_pkg::pol_e CLK_POL = dpram_pkg::POL_NORMAL,
  parameter dpram_pkg::pol_e EN_POL  = dpram_pkg::POL_NORMAL,
  localparam int unsigned TOTAL = WIDTH << ADDR_W
) (
  input logic              wr_clk,
  input logic              wr_enable,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WIDTH-1:0]  q_wside,
  input logic [WIDTH-1:0]  q_rside,
  input logic [TOTAL-1:0]  store_bits
);
  logic ck;
  logic wen;
  logic armed = 1'b0;

  assign ck  = (CLK_POL == dpram_pkg::POL_INVERTED) ? ~wr_clk : wr_clk;
  assign wen = (EN_POL == dpram_pkg::POL_INVERTED) ? ~wr_enable : wr_enable;

  always_ff @(posedge ck) armed <= 1'b1;

  p_write_lands_r2: assert property (@(posedge ck) disable iff (!armed)
    wen |=> store_bits[$past(wr_addr)*WIDTH +: WIDTH] == $past(wr_data));

  p_idle_keeps_r5: assert property (@(posedge ck) disable iff (!armed)
    !wen |=> $stable(store_bits));

  p_wside_follows_r3: assert property (@(negedge ck) disable iff (!armed)
    q_wside == store_bits[wr_addr*WIDTH +: WIDTH]);

  p_rside_follows_r4: assert property (@(negedge ck) disable iff (!armed)
    q_rside == store_bits[rd_addr*WIDTH +: WIDTH]);
endmodule

bind lut_dpram lut_dpram_chk #(
  .ADDR_W(ADDR_W), .WIDTH(WIDTH), .CLK_POL(CLK_POL), .EN_POL(EN_POL)
) u_chk (
  .wr_clk    (wr_clk),
  .wr_enable (wr_enable),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .q_wside   (q_wside),
  .q_rside   (q_rside),
  .store_bits(store_bits)
);

// File: tb/lut_dpram_tb.sv
module lut_dpram_tb;
  localparam logic [15:0] PRE = 16'hA5C3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit over  = 0;

  // default instance
  logic       a_en = 1'b0, a_din = 1'b0;
  logic [3:0] a_addr = '0, a_raddr = '0;
  logic       qa_w, qa_r;
  logic       ref_a [16];

  // inverted-polarity, preloaded instance
  logic       b_en = 1'b1, b_din = 1'b0;
  logic [3:0] b_addr = '0, b_raddr = '0;
  logic       qb_w, qb_r;
  logic       ref_b [16];

  lut_dpram u_dut (
    .wr_clk(clk), .wr_enable(a_en), .wr_addr(a_addr), .wr_data(a_din),
    .rd_addr(a_raddr), .q_wside(qa_w), .q_rside(qa_r)
  );

  lut_dpram #(
    .CLK_POL(dpram_pkg::POL_INVERTED), .EN_POL(dpram_pkg::POL_INVERTED),
    .INIT_BITS(PRE)
  ) u_inv (
    .wr_clk(clk), .wr_enable(b_en), .wr_addr(b_addr), .wr_data(b_din),
    .rd_addr(b_raddr), .q_wside(qb_w), .q_rside(qb_r)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // R1 / R8: power-up contents on both instances
  task automatic t_powerup();
    for (int i = 0; i < 16; i++) begin
      a_addr = 4'(i); a_raddr = 4'(15 - i);
      b_addr = 4'(i); b_raddr = 4'(15 - i);
      #0.5;
      check("R1 wside zero", qa_w, 1'b0);
      check("R1 rside zero", qa_r, 1'b0);
      check("R8 preload wside", qb_w, PRE[i]);
      check("R8 preload rside", qb_r, PRE[15 - i]);
    end
  endtask

  task automatic wr_a(input logic [3:0] ad, input logic d);
    @(posedge clk); #2;
    a_addr = ad; a_din = d; a_en = 1'b1;
    @(posedge clk); #6;
    ref_a[ad] = d;
    check("R3 new value at once", qa_w, d);
    a_en = 1'b0;
  endtask

  // R2 / R3 / R4: fill then read back through both outputs
  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr_a(4'(i), 1'(i[0] ^ i[2] ^ i[3]));
    for (int i = 0; i < 16; i++) begin
      a_addr = 4'(i); a_raddr = 4'(i ^ 5);
      #1;
      check("R2 stored word", qa_w, ref_a[i]);
      check("R4 rside word", qa_r, ref_a[i ^ 5]);
    end
  endtask

  // R5: enable low, data toggling, three edges
  task automatic t_idle();
    @(posedge clk); #2;
    a_en = 1'b0; a_addr = 4'd6; a_din = ~ref_a[6]; a_raddr = 4'd6;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #6;
      check("R5 no write wside", qa_w, ref_a[6]);
      check("R5 no write rside", qa_r, ref_a[6]);
      a_din = ~a_din;
    end
    a_din = 1'b0;
  endtask

  // R9: read address equals write address during the write
  task automatic t_collide(input logic [3:0] ad);
    logic nv;
    nv = ~ref_a[ad];
    @(posedge clk); #2;
    a_addr = ad; a_raddr = ad; a_din = nv; a_en = 1'b1;
    #1;
    check("R9 old before edge", qa_r, ~nv);
    @(posedge clk); #6;
    ref_a[ad] = nv;
    check("R9 new after edge", qa_r, nv);
    check("R3 collide wside", qa_w, nv);
    a_en = 1'b0;
  endtask

  // R4: other read address unaffected by a write elsewhere
  task automatic t_independent();
    a_raddr = 4'd12;
    wr_a(4'd3, ~ref_a[3]);
    check("R4 untouched word", qa_r, ref_a[12]);
  endtask

  // R2 / R3 / R4: random traffic against the reference array
  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      @(posedge clk); #2;
      a_en = 1'($urandom); a_addr = 4'($urandom); a_din = 1'($urandom);
      a_raddr = (n % 5 == 0) ? a_addr : 4'($urandom);
      @(posedge clk); #6;
      if (a_en) ref_a[a_addr] = a_din;
      check("R3 random wside", qa_w, ref_a[a_addr]);
      check("R4 random rside", qa_r, ref_a[a_raddr]);
      a_en = 1'b0;
    end
  endtask

  // R6 / R7: inverted clock and enable
  task automatic t_inverted(input logic [3:0] ad);
    logic nv;
    nv = ~ref_b[ad];
    @(negedge clk); #2;
    b_addr = ad; b_raddr = ad; b_din = nv; b_en = 1'b0;
    @(posedge clk); #2;
    check("R6 rising edge ignored", qb_w, ~nv);
    @(negedge clk); #2;
    ref_b[ad] = nv;
    check("R6 falling edge writes", qb_w, nv);
    check("R7 low enable writes", qb_r, nv);
    b_en = 1'b1; b_din = ~nv;
    @(negedge clk); #2;
    check("R7 high enable blocks", qb_w, nv);
  endtask

  // R8: enable held inactive, table stays fixed over several edges
  task automatic t_rom();
    b_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #2;
      b_addr = 4'(i); b_raddr = 4'(i); b_din = ~ref_b[i];
      @(negedge clk); #2;
      check("R8 table wside", qb_w, ref_b[i]);
      check("R8 table rside", qb_r, ref_b[i]);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ref_a[i] = 1'b0;
      ref_b[i] = PRE[i];
    end
    #1;
    t_powerup();
    t_fill();
    t_idle();
    t_collide(4'd9);
    t_collide(4'd0);
    t_independent();
    t_random();
    t_rom();
    t_inverted(4'd2);
    t_inverted(4'd7);
    t_rom();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end
endmodule